// File: doc/BRIEF.md
# SPI Host Register Block

This block is the processor-facing half of a simple SPI master. It decodes a small 32-bit register space, keeps an eight-word queue of outgoing words and an eight-word queue of incoming words, and raises one interrupt line. The serial shifter sits outside the block. Outgoing words are handed to it over a valid/ready word handshake, and it returns each received word with a one-cycle strobe.

Software fills the outgoing queue through the data address. It sets the receive threshold to the number of words it queued and then sets the enable bit. The block presents words to the shifter while it is enabled and words are waiting. When the received count reaches the threshold, a latched receive-complete flag is set. Software then drains the incoming queue through the same data address and clears the flag by writing a one to it.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, every readable register returns 0. `irq`, `tx_valid` and `frame_active` are low, and both queues are empty.
- R2: The following writes are stored and read back as written:
  - the full 32 bits at 0x04, 0x08, 0x0C and 0x10;
  - bit 0 only at 0x00, which is the enable;
  - bits 3 and 0 only at 0x18, which are the interrupt enables;
  - bits 11:8 (transmit threshold) and 3:0 (receive threshold) at 0x20.

  Bits 12 and 4 at 0x20 always read as 0.
- R3: Each word written to 0x24 is presented on `tx_word` in write order. A word leaves the queue at a clock edge where `tx_valid` and `tx_ready` are both high. A write to 0x24 while eight words are held is dropped.
- R4: While bit 0 at 0x00 is 0, `tx_valid` and `frame_active` stay low even when words are queued.
- R5: `frame_active` is high exactly when the block is enabled and the outgoing queue holds at least one word.
- R6: Received words read from 0x24 come back in arrival order. Status bit 0 at 0x14 is 1 whenever the incoming queue is not empty. Reading 0x24 with the incoming queue empty returns 0 and changes nothing.
- R7: An `rx_valid` strobe that arrives while eight received words are held drops the word and sets bit 0 at 0x1C (overrun).
- R8: With a nonzero receive threshold, bit 3 at 0x1C (receive complete) is set by the arrival that brings the count equal to the threshold, and it stays set after the queue is read. Bit 9 at 0x1C is a live indication that the count is at or above a nonzero threshold.
- R9: The transmit hand-off that empties the outgoing queue sets bit 4 at 0x1C (transmit complete).
- R10: Writing 0x1C with a 1 in bit 4, 3 or 0 clears that flag. If a new event for the same flag occurs in the same cycle as its clear, the flag stays set.
- R11: `irq` is high when (bit 3 at 0x1C and enable bit 3 at 0x18) or (bit 0 at 0x1C and enable bit 0 at 0x18) are both set. Transmit complete never drives `irq`.
- R12: Writing 0x20 with bit 12 set empties the outgoing queue, and with bit 4 set empties the incoming queue, in that cycle. A flush wins over a push to the same queue in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read at 0x24 pops the incoming queue |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tx_word | output | 32 | Head of the outgoing queue |
| tx_valid | output | 1 | A word is offered to the shifter |
| tx_ready | input | 1 | Shifter takes the offered word |
| rx_word | input | 32 | Word from the shifter |
| rx_valid | input | 1 | `rx_word` is delivered this cycle |
| frame_active | output | 1 | Frame is held while words remain |
| cfg_clock | output | 32 | Clock setup register for the shifter |
| cfg_txword | output | 32 | Transmit word setup register |
| cfg_rxword | output | 32 | Receive word setup register |
| cfg_frame | output | 32 | Frame setup register |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, queue pushes and pops, and flag updates take effect at the rising edge where the strobe is seen. `rdata`, `tx_word`, `tx_valid`, `frame_active` and `irq` follow combinationally from the registered state. Each result is therefore due one edge after its stimulus, except read data, which is due in the same cycle as the address.

The bench changes inputs at falling edges and leaves exactly one rising edge between a stimulus and its check. It samples read data one nanosecond after setting the address, before the popping edge arrives. The two same-cycle collisions, flush against push and clear against event, are driven into a single edge so the priority order is observed directly.

// File: rtl/spi_rf_pkg.sv
// Shared constants for the SPI host register block: register offsets,
// control and flag bit positions, and field widths.
package spi_rf_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 6;
    localparam int TH_W   = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CLOCK = 6'h04;
    localparam logic [ADDR_W-1:0] A_TXWD  = 6'h08;
    localparam logic [ADDR_W-1:0] A_RXWD  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_FRAME = 6'h10;
    localparam logic [ADDR_W-1:0] A_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] A_IEN   = 6'h18;
    localparam logic [ADDR_W-1:0] A_ISR   = 6'h1C;
    localparam logic [ADDR_W-1:0] A_FCTL  = 6'h20;
    localparam logic [ADDR_W-1:0] A_DATA  = 6'h24;

    localparam int B_FLUSH_TX = 12;
    localparam int B_FLUSH_RX = 4;
    localparam int B_TXTH_LO  = 8;
    localparam int B_RXTH_LO  = 0;
    localparam int B_TC       = 4;
    localparam int B_RC       = 3;
    localparam int B_OV       = 0;
    localparam int B_THR      = 9;

    typedef struct packed {
        logic tc;
        logic rc;
        logic ov;
    } flags_t;
endpackage

// File: rtl/spi_rf_fifo.sv
// Synchronous word queue with flush.
// Assumes: pushes while full and pops while empty are ignored; flush has
// priority over push and pop in the same cycle. Empty head reads as zero.
module spi_rf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = empty ? '0 : mem[rd_ptr];

    // storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_rf_irq.sv
// Latched interrupt flags with write-one-to-clear and the masked request.
// Assumes: an event in the same cycle as its clear leaves the flag set.
module spi_rf_irq
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  flags_t            events,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] clr_bits,
    input  logic              ien_rc,
    input  logic              ien_ov,
    output flags_t            flags,
    output logic              irq
);
    // set on event, clear on write-one, event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags.tc <= events.tc | (flags.tc & ~(clr_we & clr_bits[B_TC]));
            flags.rc <= events.rc | (flags.rc & ~(clr_we & clr_bits[B_RC]));
            flags.ov <= events.ov | (flags.ov & ~(clr_we & clr_bits[B_OV]));
        end
    end

    // request line from enabled flags only
    assign irq = (flags.rc & ien_rc) | (flags.ov & ien_ov);
endmodule

// File: rtl/spi_host_regs.sv
// Host-side register block of an SPI master: register decode, transmit and
// receive word queues, thresholds, interrupt flags and the enable gate.
// Assumes: single-cycle register accesses; the shifter holds tx_ready only
// while it can take a word and strobes rx_valid once per received word.
module spi_host_regs
    import spi_rf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_valid,
    output logic              frame_active,
    output logic [WORD_W-1:0] cfg_clock,
    output logic [WORD_W-1:0] cfg_txword,
    output logic [WORD_W-1:0] cfg_rxword,
    output logic [WORD_W-1:0] cfg_frame,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             enable, ien_rc, ien_ov;
    logic [TH_W-1:0]  tx_th, rx_th;
    logic             tx_flush, rx_flush, tx_push, rx_pop, tx_pop;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic             thr_hit;
    flags_t           events, flags;

    // bus strobes decoded per address
    assign tx_flush = wr_en && (addr == A_FCTL) && wdata[B_FLUSH_TX];
    assign rx_flush = wr_en && (addr == A_FCTL) && wdata[B_FLUSH_RX];
    assign tx_push  = wr_en && (addr == A_DATA);
    assign rx_pop   = rd_en && (addr == A_DATA);
    assign tx_pop   = tx_valid && tx_ready;

    // configuration and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable     <= 1'b0;
            ien_rc     <= 1'b0;
            ien_ov     <= 1'b0;
            tx_th      <= '0;
            rx_th      <= '0;
            cfg_clock  <= '0;
            cfg_txword <= '0;
            cfg_rxword <= '0;
            cfg_frame  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:  enable     <= wdata[0];
                A_CLOCK: cfg_clock  <= wdata;
                A_TXWD:  cfg_txword <= wdata;
                A_RXWD:  cfg_rxword <= wdata;
                A_FRAME: cfg_frame  <= wdata;
                A_IEN: begin
                    ien_rc <= wdata[B_RC];
                    ien_ov <= wdata[B_OV];
                end
                A_FCTL: begin
                    tx_th <= wdata[B_TXTH_LO +: TH_W];
                    rx_th <= wdata[B_RXTH_LO +: TH_W];
                end
                default: ;
            endcase
        end
    end

    spi_rf_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .din(wdata),
        .pop(tx_pop), .dout(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_rf_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_valid), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    // enable gate on the shifter side
    assign tx_valid     = enable && !tx_empty;
    assign frame_active = enable && !tx_empty;

    // flag events and the live threshold indication
    always_comb begin
        events.ov = rx_valid && rx_full && !rx_flush;
        events.rc = rx_valid && !rx_full && !rx_flush && (rx_th != '0) &&
                    (8'(rx_cnt) + 8'd1 == 8'(rx_th));
        events.tc = tx_pop && (tx_cnt == CNT_W'(1)) && !tx_push && !tx_flush;
        thr_hit   = (rx_th != '0) && (8'(rx_cnt) >= 8'(rx_th));
    end

    spi_rf_irq u_irq (
        .clk(clk), .rst_n(rst_n), .events(events),
        .clr_we(wr_en && (addr == A_ISR)), .clr_bits(wdata),
        .ien_rc(ien_rc), .ien_ov(ien_ov), .flags(flags), .irq(irq)
    );

    // read data mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[0] = enable;
            A_CLOCK: rdata = cfg_clock;
            A_TXWD:  rdata = cfg_txword;
            A_RXWD:  rdata = cfg_rxword;
            A_FRAME: rdata = cfg_frame;
            A_STAT:  rdata[0] = !rx_empty;
            A_IEN: begin
                rdata[B_RC] = ien_rc;
                rdata[B_OV] = ien_ov;
            end
            A_ISR: begin
                rdata[B_THR] = thr_hit;
                rdata[B_TC]  = flags.tc;
                rdata[B_RC]  = flags.rc;
                rdata[B_OV]  = flags.ov;
            end
            A_FCTL: begin
                rdata[B_TXTH_LO +: TH_W] = tx_th;
                rdata[B_RXTH_LO +: TH_W] = rx_th;
            end
            A_DATA:  rdata = rx_head;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_host_regs_chk.sv
// Property checker for spi_host_regs, attached by bind below.
// Assumes: it only observes; every property is gated by reset.
module spi_host_regs_chk
    import spi_rf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [WORD_W-1:0]          wdata,
    input logic                       enable,
    input logic                       tx_valid,
    input logic                       tx_ready,
    input logic                       frame_active,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       rx_valid,
    input logic                       rx_full,
    input logic                       ien_rc,
    input logic                       ien_ov,
    input flags_t                     flags,
    input logic                       irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic wr_data, wr_fctl, clr_ov;
    assign wr_data = wr_en && (addr == A_DATA);
    assign wr_fctl = wr_en && (addr == A_FCTL);
    assign clr_ov  = wr_en && (addr == A_ISR) && wdata[B_OV];

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!tx_valid && !frame_active));

    // R3
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(DEPTH));

    // R3
    tx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wr_data && !wr_fctl) |=> (tx_cnt == $past(tx_cnt) - 1'b1));

    // R7
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && !(wr_fctl && wdata[B_FLUSH_RX])) |=> flags.ov);

    // R10
    ov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ov && !(rx_valid && rx_full)) |=> !flags.ov);

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_rc && !ien_ov) |-> !irq);

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0 && rd_en && addr == A_DATA && !rx_valid) |=> (rx_cnt == '0));
endmodule

bind spi_host_regs spi_host_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .enable(enable), .tx_valid(tx_valid), .tx_ready(tx_ready), .frame_active(frame_active),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_valid(rx_valid), .rx_full(rx_full),
    .ien_rc(ien_rc), .ien_ov(ien_ov), .flags(flags), .irq(irq)
);

// File: tb/tb_spi_host_regs.sv
module tb_spi_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0, rx_word = '0;
    logic [31:0] rdata, tx_word, cfg_clock, cfg_txword, cfg_rxword, cfg_frame;
    logic        tx_valid, frame_active, irq;
    int total = 0, bad = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    spi_host_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_word(tx_word), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_word(rx_word), .rx_valid(rx_valid),
        .frame_active(frame_active), .cfg_clock(cfg_clock), .cfg_txword(cfg_txword),
        .cfg_rxword(cfg_rxword), .cfg_frame(cfg_frame), .irq(irq)
    );

    // {address, write value, expected read value}
    localparam logic [69:0] VEC [7] = '{
        {6'h04, 32'hDEADBEEF, 32'hDEADBEEF},
        {6'h08, 32'h12345678, 32'h12345678},
        {6'h0C, 32'hA5A5A5A5, 32'hA5A5A5A5},
        {6'h10, 32'h0000C000, 32'h0000C000},
        {6'h18, 32'hFFFFFFFF, 32'h00000009},
        {6'h20, 32'hFFFFFFFF, 32'h00000F0F},
        {6'h00, 32'hFFFFFFFE, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rdreg(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rx_push(input logic [31:0] w);
        @(negedge clk); rx_valid = 1'b1; rx_word = w;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_valid", {31'b0, tx_valid}, 0);
        chk("R1 frame", {31'b0, frame_active}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        foreach (VEC[i]) begin
            rdreg(VEC[i][69:64], rd);
            chk("R1 register", rd, 0);
        end
        rdreg(6'h14, rd); chk("R1 status", rd, 0);
        rdreg(6'h1C, rd); chk("R1 isr", rd, 0);

        // R2 table walk
        foreach (VEC[i]) begin
            wr(VEC[i][69:64], VEC[i][63:32]);
            rdreg(VEC[i][69:64], rd);
            chk("R2 readback", rd, VEC[i][31:0]);
        end
        wr(6'h18, 0); wr(6'h20, 0);

        // R4 gate, then R5 and R3 ordering, R9 completion
        wr(6'h24, 32'hA); wr(6'h24, 32'hB); wr(6'h24, 32'hC);
        chk("R4 tx_valid off", {31'b0, tx_valid}, 0);
        chk("R4 frame off", {31'b0, frame_active}, 0);
        wr(6'h00, 1);
        chk("R5 frame on", {31'b0, frame_active}, 1);
        chk("R3 head A", tx_word, 32'hA);
        tx_take(); chk("R3 head B", tx_word, 32'hB);
        tx_take(); chk("R3 head C", tx_word, 32'hC);
        rdreg(6'h1C, rd); chk("R9 not yet", rd & 32'h10, 0);
        tx_take();
        chk("R5 frame off when empty", {31'b0, frame_active}, 0);
        chk("R3 tx_valid empty", {31'b0, tx_valid}, 0);
        rdreg(6'h1C, rd); chk("R9 tc set", rd & 32'h10, 32'h10);

        // R3 drop on full
        wr(6'h00, 0);
        for (int i = 0; i < 9; i++) wr(6'h24, 32'h100 + i);
        wr(6'h00, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R3 full order", tx_word, 32'h100 + i);
            tx_take();
        end
        chk("R3 ninth dropped", {31'b0, tx_valid}, 0);
        wr(6'h00, 0);

        // R10 clear tc
        wr(6'h1C, 32'h10);
        rdreg(6'h1C, rd); chk("R10 tc cleared", rd, 0);

        // R8 threshold, R11 irq, R6 order and empty read
        wr(6'h20, 32'h3); wr(6'h18, 32'h8);
        rx_push(32'h11); rx_push(32'h22);
        rdreg(6'h14, rd); chk("R6 status nonempty", rd, 1);
        rdreg(6'h1C, rd); chk("R8 below threshold", rd, 0);
        chk("R11 irq low", {31'b0, irq}, 0);
        rx_push(32'h33);
        rdreg(6'h1C, rd); chk("R8 rc and level", rd, 32'h208);
        chk("R11 irq high", {31'b0, irq}, 1);
        rdreg(6'h24, rd); chk("R6 word 1", rd, 32'h11);
        rdreg(6'h24, rd); chk("R6 word 2", rd, 32'h22);
        rdreg(6'h24, rd); chk("R6 word 3", rd, 32'h33);
        rdreg(6'h24, rd); chk("R6 empty read", rd, 0);
        rdreg(6'h14, rd); chk("R6 status empty", rd, 0);
        rdreg(6'h1C, rd); chk("R8 rc latched", rd, 32'h8);
        wr(6'h1C, 32'h8);
        chk("R10 irq after clear", {31'b0, irq}, 0);

        // R7 overrun with masked then unmasked irq
        wr(6'h20, 0); wr(6'h18, 0);
        for (int i = 0; i < 9; i++) rx_push(32'h200 + i);
        rdreg(6'h1C, rd); chk("R7 overrun flag", rd, 1);
        chk("R11 masked", {31'b0, irq}, 0);
        wr(6'h18, 1);
        chk("R11 ov enabled", {31'b0, irq}, 1);
        for (int i = 0; i < 8; i++) begin
            rdreg(6'h24, rd); chk("R7 kept words", rd, 32'h200 + i);
        end
        rdreg(6'h24, rd); chk("R7 ninth dropped", rd, 0);
        wr(6'h1C, 1); wr(6'h18, 0);

        // R12 flush, flush wins over push
        rx_push(32'h5); rx_push(32'h6);
        wr(6'h24, 1); wr(6'h24, 2);
        @(negedge clk); wr_en = 1'b1; addr = 6'h20; wdata = 32'h1010;
        rx_valid = 1'b1; rx_word = 32'h7;
        @(negedge clk); wr_en = 1'b0; rx_valid = 1'b0;
        rdreg(6'h14, rd); chk("R12 rx flushed", rd, 0);
        wr(6'h00, 1);
        chk("R12 tx flushed", {31'b0, tx_valid}, 0);
        wr(6'h00, 0);

        // R10 event beats clear
        for (int i = 0; i < 8; i++) rx_push(i);
        @(negedge clk); wr_en = 1'b1; addr = 6'h1C; wdata = 32'h1;
        rx_valid = 1'b1; rx_word = 32'hF;
        @(negedge clk); wr_en = 1'b0; rx_valid = 1'b0;
        rdreg(6'h1C, rd); chk("R10 set wins", rd & 1, 1);
        wr(6'h1C, 1);
        rdreg(6'h1C, rd); chk("R10 cleared", rd & 1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule